// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block is the control and register core of a 16-bit processor with one accumulator and a one-bit carry flag. A step counter walks each instruction through numbered timing steps. The core fetches the word that the program counter points at, decodes it, and follows one level of pointer when the word asks for indirect addressing. It then executes one of seven memory-reference operations and clears the step counter, so that the next fetch begins. Instructions run one after another. Nothing overlaps, and each operation takes as many steps as it needs.

Words whose opcode field is all ones are not executed here. The core raises a hand-off strobe, shows the low twelve bits and the mode bit of the instruction, and waits in step 3 until an external register/IO unit answers with a done pulse.

Memory is a single port of 4096 words of 16 bits. The address comes straight from the address register. Read data is returned in the same cycle, and a write takes effect at the clock edge on which the write enable is high.

Top module: `accum_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the step output is 0, the program counter holds the START_ADDR parameter, the accumulator and carry flag are 0, and neither the write enable nor the hand-off strobe is high.
- R2: An instruction word uses bit 15 as the indirect flag, bits 14..12 as the opcode and bits 11..0 as the address. In step 0 the address register takes the program counter. In step 1 the word at that address is latched and the program counter is incremented. In step 2 the memory address output takes the address field.
- R3: If bit 15 is 1 and the opcode is 0..6, step 3 replaces the address register with bits 11..0 of the word it points at. If bit 15 is 0, the address is left unchanged.
- R4: Opcode 0 ANDs the operand into the accumulator. Opcode 2 copies the operand into the accumulator. Both complete in step 5.
- R5: Opcode 1 adds the operand to the accumulator in step 5 and puts the carry-out of bit 15 into the carry flag.
- R6: Opcode 3 writes the accumulator to the effective address in step 4 and completes there.
- R7: Opcode 4 loads the effective address into the program counter in step 4 and completes there.
- R8: Opcode 5 writes the incremented program counter, zero-extended, to the effective address in step 4. In step 5 it loads the effective address plus one into the program counter.
- R9: Opcode 6 reads the operand in step 4 and increments it in step 5. In step 6 it writes the incremented value back and, if that value is zero, adds one to the program counter.
- R10: Opcode 7 raises the hand-off strobe in step 3, with the address field on the code output and bit 15 on the mode output. The step counter stays at 3 until the done input is seen high, and then the instruction ends with no change to the program counter, accumulator or carry. The done input has no effect at any other time.
- R11: The step counter advances by one on every clock and returns to 0 after the last step of each instruction. Instruction lengths are: opcodes 3 and 4 take 5 cycles; opcodes 0, 1, 2 and 5 take 6; opcode 6 takes 7; opcode 7 takes 4 plus the cycles spent waiting for done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memRdData | input | 16 | Word at memAddr, same cycle |
| memAddr | output | 12 | Memory address (address register) |
| memWrData | output | 16 | Write data |
| memWrEn | output | 1 | Write strobe, taken at the clock edge |
| extDone | input | 1 | Register/IO unit finished |
| extStart | output | 1 | Hand-off strobe for opcode 7 |
| extCode | output | 12 | Address field of the handed-off instruction |
| extIo | output | 1 | Mode bit of the handed-off instruction |
| stepOut | output | 3 | Current timing step |
| pcOut | output | 12 | Program counter |
| acOut | output | 16 | Accumulator |
| eOut | output | 1 | Carry flag |

## Verification
Each result belongs to a known step. The fetch address appears on memAddr during steps 1 and 2, the decoded address during step 3, and the effective address from step 4 onward. Write strobes appear during steps 4 or 6. The program counter shows its increment from step 2 onward, while accumulator, carry and branch results first appear in step 0 of the following instruction. The bench model expands every instruction into one expected record per cycle, with the correct step number, and compares the outputs against it in the middle of each cycle. As a result, a value that arrives a cycle early or late is reported at the step where it went wrong.

// File: rtl/accseq_pkg.sv
package accseq_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 16;
  localparam int STEP_W  = 3;
  localparam int IND_BIT = DATA_W - 1;
  localparam int OPC_LSB = ADDR_W;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_ADD = 3'd1,
    OP_LDA = 3'd2,
    OP_STA = 3'd3,
    OP_BUN = 3'd4,
    OP_BSA = 3'd5,
    OP_ISZ = 3'd6,
    OP_EXT = 3'd7
  } opcode_e;

  typedef struct packed {
    logic arLdPc;
    logic arLdIr;
    logic arLdMem;
    logic arInc;
    logic irLd;
    logic pcInc;
    logic pcLdAr;
    logic pcSkipZ;
    logic drLdMem;
    logic drInc;
    logic acAnd;
    logic acAdd;
    logic acLd;
    logic wrAc;
    logic wrPc;
    logic wrDr;
  } strobe_t;
endpackage

// File: rtl/accseq_control.sv
module accseq_control
  import accseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        irHi,
  input  logic              extDone,
  output strobe_t           st,
  output logic [STEP_W-1:0] stepCnt,
  output logic              extStart,
  output logic              extIo
);
  localparam logic [STEP_W-1:0] S0 = STEP_W'(0);
  localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
  localparam logic [STEP_W-1:0] S2 = STEP_W'(2);
  localparam logic [STEP_W-1:0] S3 = STEP_W'(3);
  localparam logic [STEP_W-1:0] S4 = STEP_W'(4);
  localparam logic [STEP_W-1:0] S5 = STEP_W'(5);
  localparam logic [STEP_W-1:0] S6 = STEP_W'(6);

  opcode_e opc;
  logic    iFlag;
  logic    endIns;
  logic    waitExt;

  assign opc     = opcode_e'(irHi[2:0]);
  assign extIo   = iFlag;
  assign waitExt = extStart && !extDone;

  always_comb begin
    st       = '0;
    endIns   = 1'b0;
    extStart = 1'b0;
    case (stepCnt)
      S0: st.arLdPc = 1'b1;
      S1: begin st.irLd = 1'b1; st.pcInc = 1'b1; end
      S2: st.arLdIr = 1'b1;
      S3: begin
        if (opc == OP_EXT) begin
          extStart = 1'b1;
          endIns   = extDone;
        end else if (iFlag) begin
          st.arLdMem = 1'b1;
        end
      end
      S4: begin
        case (opc)
          OP_AND, OP_ADD, OP_LDA, OP_ISZ: st.drLdMem = 1'b1;
          OP_STA: begin st.wrAc = 1'b1; endIns = 1'b1; end
          OP_BUN: begin st.pcLdAr = 1'b1; endIns = 1'b1; end
          OP_BSA: begin st.wrPc = 1'b1; st.arInc = 1'b1; end
          default: endIns = 1'b1;
        endcase
      end
      S5: begin
        case (opc)
          OP_AND: begin st.acAnd = 1'b1; endIns = 1'b1; end
          OP_ADD: begin st.acAdd = 1'b1; endIns = 1'b1; end
          OP_LDA: begin st.acLd = 1'b1; endIns = 1'b1; end
          OP_BSA: begin st.pcLdAr = 1'b1; endIns = 1'b1; end
          OP_ISZ: st.drInc = 1'b1;
          default: endIns = 1'b1;
        endcase
      end
      S6: begin
        if (opc == OP_ISZ) begin
          st.wrDr    = 1'b1;
          st.pcSkipZ = 1'b1;
        end
        endIns = 1'b1;
      end
      default: endIns = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= S0;
      iFlag   <= 1'b0;
    end else begin
      if (endIns)        stepCnt <= S0;
      else if (!waitExt) stepCnt <= stepCnt + STEP_W'(1);
      if (stepCnt == S2) iFlag <= irHi[3];
    end
  end

  // R11
  step_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    endIns |=> stepCnt == S0);
  // R11
  step_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!endIns && !waitExt) |=> stepCnt == $past(stepCnt) + STEP_W'(1));
  // R10
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    waitExt |=> extStart && $stable(irHi) && stepCnt == S3);
endmodule

// File: rtl/accseq_datapath.sv
module accseq_datapath
  import accseq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWrEn,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ac,
  output logic              e
);
  logic [ADDR_W-1:0] ar;
  logic [DATA_W-1:0] dr;
  logic [DATA_W:0]   sum;

  assign sum     = {1'b0, ac} + {1'b0, dr};
  assign memAddr = ar;
  assign memWrEn = st.wrAc | st.wrPc | st.wrDr;

  always_comb begin
    if (st.wrAc)      memWrData = ac;
    else if (st.wrPc) memWrData = DATA_W'(pc);
    else              memWrData = dr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ar <= '0;
      pc <= START_ADDR;
      ir <= '0;
      dr <= '0;
      ac <= '0;
      e  <= 1'b0;
    end else begin
      if (st.arLdPc)       ar <= pc;
      else if (st.arLdIr)  ar <= ir[ADDR_W-1:0];
      else if (st.arLdMem) ar <= memRdData[ADDR_W-1:0];
      else if (st.arInc)   ar <= ar + ADDR_W'(1);

      if (st.irLd) ir <= memRdData;

      if (st.pcInc)                        pc <= pc + ADDR_W'(1);
      else if (st.pcLdAr)                  pc <= ar;
      else if (st.pcSkipZ && dr == '0)     pc <= pc + ADDR_W'(1);

      if (st.drLdMem)    dr <= memRdData;
      else if (st.drInc) dr <= dr + DATA_W'(1);

      if (st.acAnd)      ac <= ac & dr;
      else if (st.acAdd) {e, ac} <= sum;
      else if (st.acLd)  ac <= dr;
    end
  end

  // R2
  pc_fetch_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.irLd |=> pc == $past(pc) + ADDR_W'(1));
  // R3
  indirect_ea_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.arLdMem |=> memAddr == $past(memRdData[ADDR_W-1:0]));
  // R5
  add_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.acAdd |=> {e, ac} == $past({1'b0, ac}) + $past({1'b0, dr}));
  // R6
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({st.wrAc, st.wrPc, st.wrDr}) <= 1);
endmodule

// File: rtl/accum_sequencer.sv
module accum_sequencer
  import accseq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] START_ADDR = 12'h010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWrEn,
  input  logic              extDone,
  output logic              extStart,
  output logic [ADDR_W-1:0] extCode,
  output logic              extIo,
  output logic [STEP_W-1:0] stepOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] acOut,
  output logic              eOut
);
  strobe_t           st;
  logic [DATA_W-1:0] irWord;

  assign extCode = irWord[ADDR_W-1:0];

  accseq_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irHi     (irWord[DATA_W-1:OPC_LSB]),
    .extDone  (extDone),
    .st       (st),
    .stepCnt  (stepOut),
    .extStart (extStart),
    .extIo    (extIo)
  );

  accseq_datapath #(.START_ADDR(START_ADDR)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memWrEn   (memWrEn),
    .ir        (irWord),
    .pc        (pcOut),
    .ac        (acOut),
    .e         (eOut)
  );
endmodule

// File: tb/test_accum_sequencer.sv
module test_accum_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] START = 12'h010;
  localparam int NINSTR = 17;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memRdData;
  logic [11:0] memAddr;
  logic [15:0] memWrData;
  logic        memWrEn;
  logic        extDone = 1'b0;
  logic        extStart;
  logic [11:0] extCode;
  logic        extIo;
  logic [2:0]  stepOut;
  logic [11:0] pcOut;
  logic [15:0] acOut;
  logic        eOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [15:0] ram    [0:4095];
  logic [15:0] refMem [0:4095];

  typedef struct {
    int          step;
    int          addr;
    bit          wr;
    logic [15:0] wdata;
    logic [11:0] pc;
    logic [15:0] ac;
    bit          e;
    bit          ext;
    bit          done;
    logic [11:0] code;
    bit          io;
    int          tag;
  } expRec;

  expRec expQ[$];
  int    extDelays[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memRdData = ram[memAddr];
  always @(posedge clk) if (memWrEn) ram[memAddr] <= memWrData;

  accum_sequencer #(.START_ADDR(START)) i_accum_sequencer (
    .clk(clk), .rstN(rstN), .memRdData(memRdData), .memAddr(memAddr),
    .memWrData(memWrData), .memWrEn(memWrEn), .extDone(extDone),
    .extStart(extStart), .extCode(extCode), .extIo(extIo),
    .stepOut(stepOut), .pcOut(pcOut), .acOut(acOut), .eOut(eOut));

  task automatic check(input bit ok, input int tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] v);
    ram[a] = v;
    refMem[a] = v;
  endtask

  task automatic push(input int step, input int addr, input bit wr, input logic [15:0] wd,
                      input logic [11:0] pc, input logic [15:0] ac, input bit e,
                      input bit ext, input bit done, input logic [11:0] code,
                      input bit io, input int tag);
    expRec r;
    r.step = step; r.addr = addr; r.wr = wr; r.wdata = wd; r.pc = pc; r.ac = ac;
    r.e = e; r.ext = ext; r.done = done; r.code = code; r.io = io; r.tag = tag;
    expQ.push_back(r);
  endtask

  // Behavioural model: expands each instruction into one expected record per cycle.
  task automatic buildTrace();
    logic [11:0] pc = START;
    logic [15:0] ac = '0;
    bit          e = 1'b0;
    for (int n = 0; n < NINSTR; n++) begin
      logic [15:0] w = refMem[pc];
      bit          ind = w[15];
      int          op = int'(w[14:12]);
      logic [11:0] a = w[11:0];
      logic [11:0] pc1 = pc + 12'd1;
      logic [11:0] ea;
      logic [15:0] m;
      logic [16:0] s;
      int          t4;
      push(0, -1, 0, 0, pc, ac, e, 0, 0, 0, 0, 2);
      push(1, int'(pc), 0, 0, pc, ac, e, 0, 0, 0, 0, 2);
      push(2, int'(pc), 0, 0, pc1, ac, e, 0, 0, 0, 0, 2);
      if (op == 7) begin
        int d = extDelays.pop_front();
        for (int k = 0; k <= d; k++)
          push(3, int'(a), 0, 0, pc1, ac, e, 1, k == d, a, ind, 10); // R10
        pc = pc1;
        continue;
      end
      push(3, int'(a), 0, 0, pc1, ac, e, 0, 0, 0, 0, 2);
      ea = ind ? refMem[a][11:0] : a;
      m = refMem[ea];
      t4 = ind ? 3 : 11; // R3 shows as the step-4 address
      case (op)
        0: begin push(4, int'(ea), 0, 0, pc1, ac, e, 0, 0, 0, 0, t4);
                 push(5, int'(ea), 0, 0, pc1, ac, e, 0, 0, 0, 0, 4); ac = ac & m; end // R4
        1: begin push(4, int'(ea), 0, 0, pc1, ac, e, 0, 0, 0, 0, t4);
                 push(5, int'(ea), 0, 0, pc1, ac, e, 0, 0, 0, 0, 5);
                 s = {1'b0, ac} + {1'b0, m}; ac = s[15:0]; e = s[16]; end // R5
        2: begin push(4, int'(ea), 0, 0, pc1, ac, e, 0, 0, 0, 0, t4);
                 push(5, int'(ea), 0, 0, pc1, ac, e, 0, 0, 0, 0, 4); ac = m; end
        3: begin push(4, int'(ea), 1, ac, pc1, ac, e, 0, 0, 0, 0, ind ? 3 : 6);
                 refMem[ea] = ac; end // R6
        4: begin push(4, int'(ea), 0, 0, pc1, ac, e, 0, 0, 0, 0, t4); pc1 = ea; end // R7
        5: begin push(4, int'(ea), 1, {4'h0, pc1}, pc1, ac, e, 0, 0, 0, 0, 8);
                 push(5, int'(ea + 12'd1), 0, 0, pc1, ac, e, 0, 0, 0, 0, 8);
                 refMem[ea] = {4'h0, pc1}; pc1 = ea + 12'd1; end // R8
        default: begin
          push(4, int'(ea), 0, 0, pc1, ac, e, 0, 0, 0, 0, t4);
          push(5, int'(ea), 0, 0, pc1, ac, e, 0, 0, 0, 0, 9);
          push(6, int'(ea), 1, m + 16'd1, pc1, ac, e, 0, 0, 0, 0, 9); // R9
          refMem[ea] = m + 16'd1;
          if (m + 16'd1 == 16'd0) pc1 = pc1 + 12'd1;
        end
      endcase
      pc = pc1;
    end
  endtask

  task automatic compare(input expRec r);
    check(stepOut == 3'(r.step), 11, "step", stepOut, r.step); // R11
    if (r.addr >= 0) check(memAddr == 12'(r.addr), r.tag, "memAddr", memAddr, r.addr);
    check(memWrEn == r.wr, r.tag, "memWrEn", memWrEn, r.wr);
    if (r.wr) check(memWrData == r.wdata, r.tag, "memWrData", memWrData, r.wdata);
    check(pcOut == r.pc, r.tag == 2 ? 2 : 7, "pc", pcOut, r.pc);
    check(acOut == r.ac, r.tag == 5 ? 5 : 4, "ac", acOut, r.ac);
    check(eOut == r.e, 5, "carry", eOut, r.e);
    check(extStart == r.ext, 10, "extStart", extStart, r.ext);
    if (r.ext) begin
      check(extCode == r.code, 10, "extCode", extCode, r.code);
      check(extIo == r.io, 10, "extIo", extIo, r.io);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin ram[i] = '0; refMem[i] = '0; end
    put(12'h010, 16'h2100); put(12'h011, 16'h1101); put(12'h012, 16'h0102);
    put(12'h013, 16'h9103); put(12'h014, 16'h3105); put(12'h015, 16'h6106);
    put(12'h016, 16'h7800); put(12'h017, 16'h6107); put(12'h018, 16'h7400);
    put(12'h019, 16'hF200); put(12'h01A, 16'h5120); put(12'h01B, 16'h4030);
    put(12'h121, 16'hA107); put(12'h122, 16'hB103); put(12'h123, 16'hC120);
    put(12'h030, 16'h2104); put(12'h031, 16'h4031);
    put(12'h100, 16'hFFFF); put(12'h101, 16'h0003); put(12'h102, 16'h00F3);
    put(12'h103, 16'h0104); put(12'h104, 16'h1000); put(12'h106, 16'hFFFF);
    put(12'h107, 16'h0005); put(12'h006, 16'h1234);
    extDelays.push_back(0);
    extDelays.push_back(3);
    buildTrace();

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(stepOut == 3'd0, 1, "reset step", stepOut, 0);
    check(pcOut == START, 1, "reset pc", pcOut, START);
    check(acOut == 16'h0 && eOut == 1'b0, 1, "reset ac/e", {eOut, acOut}, 0);
    check(!memWrEn && !extStart, 1, "reset strobes", {memWrEn, extStart}, 0);
    rstN = 1'b1;
    foreach (expQ[i]) begin
      if (i != 0) @(negedge clk);
      #1;
      compare(expQ[i]);
      // R10: done is ignored outside the hand-off wait
      extDone = expQ[i].ext ? expQ[i].done : (i % 3 == 0);
    end
    @(negedge clk);
    extDone = 1'b0;
    check(ram[12'h105] == 16'h1002, 6, "stored word", ram[12'h105], 16'h1002);
    check(ram[12'h104] == 16'h1234, 3, "indirect store", ram[12'h104], 16'h1234);
    check(ram[12'h106] == 16'h0000, 9, "isz wrap", ram[12'h106], 0);
    check(ram[12'h107] == 16'h0006, 9, "isz no skip", ram[12'h107], 6);
    check(ram[12'h120] == 16'h001B, 8, "return addr", ram[12'h120], 16'h001B);
    check(acOut == 16'h1234, 4, "final ac", acOut, 16'h1234);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule